// File: doc/BRIEF.md
# Trap Value Register Update Unit

This unit holds the trap-value register of one privilege level. When a trap is taken into that level, it decides from the exception cause what goes into the register. The candidates are the faulting virtual address, the address of the part of a split access or fetch that actually faulted, the raw bits of the offending instruction, or zero. In the same cycle it captures the exception program counter, which is the address where the trapping instruction begins. Apart from traps, the register changes only through a software write port. If a trap and a software write arrive in the same cycle, the trap wins.

A platform mask parameter has one bit per cause code. It selects which exceptions must report an informative value; the rest report zero. When the mask is all zero, the register is tied to zero. Otherwise the register is write-any-read-legal. Any value whose bits above the implemented virtual address width are not a sign extension of that width is replaced by a fixed legal pattern. This rule applies to address loads and to software writes.

Top module: `tval_unit`

## Requirements
- R1: After reset, `tval_o` and `epc_o` are zero.
- R2: A trap with cause 0 (fetch misaligned), 3 (breakpoint), 4 (load misaligned) or 6 (store misaligned) whose mask bit is set loads the legalized `fault_vaddr` on the next clock edge.
- R3: A trap with cause 1, 5 or 7 (fetch/load/store access fault) or 12, 13 or 15 (fetch/load/store page fault) whose mask bit is set loads the legalized `part_vaddr` when `part_valid` is 1, and the legalized `fault_vaddr` when it is 0.
- R4: A trap with cause 2 (illegal instruction) whose mask bit is set loads `insn_bits`, zero-extended to XLEN, with no legalization.
- R5: A trap whose mask bit is clear, or whose cause is 8 to 11 or 14, loads zero.
- R6: Every trap loads `trap_pc` into `epc_o` on the next edge, whatever the cause.
- R7: With no trap, `sw_we` loads the legalized `sw_wdata`. With neither a trap nor `sw_we`, the register holds its value.
- R8: When `trap_take` and `sw_we` are both high, the trap value is loaded and the software data is discarded.
- R9: A value is legal when bits XLEN-1 down to VA_BITS-1 are all equal. An illegal value is replaced by ones in those bits and zeros below them (0xFFF80000 for XLEN=32, VA_BITS=20).
- R10: With an all-zero mask, `tval_o` reads zero at all times, whatever traps or software writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_take | input | 1 | A trap is taken into this level this cycle |
| trap_cause | input | CAUSE_W | Exception cause code |
| trap_pc | input | XLEN | Start address of the trapping instruction |
| fault_vaddr | input | XLEN | Faulting virtual address (start of access or fetch) |
| part_vaddr | input | XLEN | Virtual address of the faulting portion |
| part_valid | input | 1 | The fault lies in a later portion given by part_vaddr |
| insn_bits | input | ILEN | Bits of the faulting instruction |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | XLEN | Software write data |
| tval_o | output | XLEN | Trap value register read port |
| epc_o | output | XLEN | Exception program counter |

## Verification
The assertions assume a synchronous reset and cause codes that fit CAUSE_W. They make no assumption about whether the address and instruction inputs are legal, because folding illegal values is part of what the block must do. Random stimulus therefore mixes sign-extended addresses with arbitrary 32-bit words. It covers every cause code, including the undefined ones, and raises `trap_take` and `sw_we` independently so that collisions occur often. Directed cases add the fold boundary, the collision with a non-zero software value, and a tied-zero instance driven by the same inputs.

// File: rtl/tval_pkg.sv
package tval_pkg;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_ADDR = 2'd1,
      SRC_INSN = 2'd2
   } tval_src_e;

   localparam int C_FETCH_MIS   = 0;
   localparam int C_FETCH_ACC   = 1;
   localparam int C_ILLEGAL     = 2;
   localparam int C_BREAK       = 3;
   localparam int C_LOAD_MIS    = 4;
   localparam int C_LOAD_ACC    = 5;
   localparam int C_STORE_MIS   = 6;
   localparam int C_STORE_ACC   = 7;
   localparam int C_FETCH_PAGE  = 12;
   localparam int C_LOAD_PAGE   = 13;
   localparam int C_STORE_PAGE  = 15;

   // which kind of value a cause reports when it is informative
   function automatic tval_src_e src_of(input int code);
      case (code)
         C_FETCH_MIS, C_FETCH_ACC, C_BREAK, C_LOAD_MIS, C_LOAD_ACC,
         C_STORE_MIS, C_STORE_ACC, C_FETCH_PAGE, C_LOAD_PAGE,
         C_STORE_PAGE:   return SRC_ADDR;
         C_ILLEGAL:      return SRC_INSN;
         default:        return SRC_ZERO;
      endcase
   endfunction

   // causes for which a split access reports the faulting portion
   function automatic logic uses_part(input int code);
      case (code)
         C_FETCH_ACC, C_LOAD_ACC, C_STORE_ACC,
         C_FETCH_PAGE, C_LOAD_PAGE, C_STORE_PAGE: return 1'b1;
         default:                                 return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tval_select.sv
module tval_select
   import tval_pkg::*;
#(
   parameter int                    XLEN      = 32,
   parameter int                    CAUSE_W   = 4,
   parameter logic [2**CAUSE_W-1:0] INFO_MASK = '1
) (
   input  logic [CAUSE_W-1:0] cause,
   input  logic [XLEN-1:0]    fault_vaddr,
   input  logic [XLEN-1:0]    part_vaddr,
   input  logic               part_valid,
   output tval_src_e          src,
   output logic [XLEN-1:0]    addr_raw
);

   int code;

   always_comb begin
      code = int'(cause);
      src  = src_of(code);
      if (!INFO_MASK[cause])
         src = SRC_ZERO;
      if (uses_part(code) && part_valid)
         addr_raw = part_vaddr;
      else
         addr_raw = fault_vaddr;
   end

endmodule

// File: rtl/tval_legal.sv
module tval_legal #(
   parameter int XLEN    = 32,
   parameter int VA_BITS = 20
) (
   input  logic [XLEN-1:0] value_in,
   output logic [XLEN-1:0] value_out
);

   localparam int UPPER_W = XLEN - VA_BITS + 1;
   localparam logic [XLEN-1:0] FOLD_PATTERN =
      {{UPPER_W{1'b1}}, {(VA_BITS-1){1'b0}}};

   logic [UPPER_W-1:0] upper;
   logic               is_legal;

   always_comb begin
      upper     = value_in[XLEN-1:VA_BITS-1];
      is_legal  = (&upper) | ~(|upper);
      value_out = is_legal ? value_in : FOLD_PATTERN;
   end

endmodule

// File: rtl/tval_unit.sv
module tval_unit
   import tval_pkg::*;
#(
   parameter int                    XLEN      = 32,
   parameter int                    ILEN      = 32,
   parameter int                    VA_BITS   = 20,
   parameter int                    CAUSE_W   = 4,
   parameter logic [2**CAUSE_W-1:0] INFO_MASK = 16'hB0BF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_take,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_pc,
   input  logic [XLEN-1:0]    fault_vaddr,
   input  logic [XLEN-1:0]    part_vaddr,
   input  logic               part_valid,
   input  logic [ILEN-1:0]    insn_bits,
   input  logic               sw_we,
   input  logic [XLEN-1:0]    sw_wdata,
   output logic [XLEN-1:0]    tval_o,
   output logic [XLEN-1:0]    epc_o
);

   localparam bit TIED_ZERO = (INFO_MASK == '0);

   if (ILEN > XLEN) begin : g_bad_ilen
      $error("tval_unit: ILEN must not exceed XLEN");
   end
   if (VA_BITS < 2 || VA_BITS > XLEN) begin : g_bad_va
      $error("tval_unit: VA_BITS must lie in 2..XLEN");
   end
   if (CAUSE_W < 4) begin : g_bad_cause
      $error("tval_unit: CAUSE_W must be at least 4");
   end

   tval_src_e         src;
   logic [XLEN-1:0]   addr_raw;
   logic [XLEN-1:0]   addr_legal;
   logic [XLEN-1:0]   sw_legal;
   logic [XLEN-1:0]   trap_value;
   logic [XLEN-1:0]   epc_q;

   tval_select #(
      .XLEN      (XLEN),
      .CAUSE_W   (CAUSE_W),
      .INFO_MASK (INFO_MASK)
   ) u_select (
      .cause       (trap_cause),
      .fault_vaddr (fault_vaddr),
      .part_vaddr  (part_vaddr),
      .part_valid  (part_valid),
      .src         (src),
      .addr_raw    (addr_raw)
   );

   tval_legal #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_legal_addr (
      .value_in  (addr_raw),
      .value_out (addr_legal)
   );

   tval_legal #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_legal_sw (
      .value_in  (sw_wdata),
      .value_out (sw_legal)
   );

   always_comb begin
      case (src)
         SRC_ADDR: trap_value = addr_legal;
         SRC_INSN: trap_value = XLEN'(insn_bits);
         default:  trap_value = '0;
      endcase
   end

   if (TIED_ZERO) begin : g_tied
      assign tval_o = '0;
   end else begin : g_reg
      logic [XLEN-1:0] tval_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            tval_q <= '0;
         else if (trap_take)
            tval_q <= trap_value;
         else if (sw_we)
            tval_q <= sw_legal;
      end
      assign tval_o = tval_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         epc_q <= '0;
      else if (trap_take)
         epc_q <= trap_pc;
   end

   assign epc_o = epc_q;

endmodule

module tval_unit_chk #(
   parameter int                    XLEN      = 32,
   parameter int                    ILEN      = 32,
   parameter int                    VA_BITS   = 20,
   parameter int                    CAUSE_W   = 4,
   parameter logic [2**CAUSE_W-1:0] INFO_MASK = 16'hB0BF
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trap_take,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [XLEN-1:0]    trap_pc,
   input logic [ILEN-1:0]    insn_bits,
   input logic               sw_we,
   input logic [XLEN-1:0]    tval_o,
   input logic [XLEN-1:0]    epc_o
);

   // R7
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_take && !sw_we) |=> $stable(tval_o));

   // R6
   epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> (epc_o == $past(trap_pc)));

   // R5
   masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take && !INFO_MASK[trap_cause]) |=> (tval_o == '0));

   // R4
   insn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_take && trap_cause == CAUSE_W'(2) && INFO_MASK[2])
      |=> (tval_o == XLEN'($past(insn_bits))));

   // R9
   sw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !trap_take) |=>
      ((&tval_o[XLEN-1:VA_BITS-1]) || !(|tval_o[XLEN-1:VA_BITS-1])));

   // R10
   always_comb begin
      if (INFO_MASK == '0)
         tied_zero_chk: assert (tval_o == '0);
   end

endmodule

bind tval_unit tval_unit_chk #(
   .XLEN      (XLEN),
   .ILEN      (ILEN),
   .VA_BITS   (VA_BITS),
   .CAUSE_W   (CAUSE_W),
   .INFO_MASK (INFO_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trap_take  (trap_take),
   .trap_cause (trap_cause),
   .trap_pc    (trap_pc),
   .insn_bits  (insn_bits),
   .sw_we      (sw_we),
   .tval_o     (tval_o),
   .epc_o      (epc_o)
);

// File: tb/tval_unit_test.sv
module tval_unit_test;

   localparam int          XLEN = 32;
   localparam int          VA   = 20;
   localparam logic [15:0] MASK = 16'hB0BF;
   localparam logic [31:0] FOLD = 32'hFFF80000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_take = 1'b0;
   logic [3:0]  trap_cause = '0;
   logic [31:0] trap_pc = '0;
   logic [31:0] fault_vaddr = '0;
   logic [31:0] part_vaddr = '0;
   logic        part_valid = 1'b0;
   logic [31:0] insn_bits = '0;
   logic        sw_we = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] tval_o, epc_o, tval_z, epc_z;

   int total = 0;
   int bad = 0;
   logic [31:0] m_tval = '0;
   logic [31:0] m_epc = '0;

   always #10 clk = ~clk;

   tval_unit uut (
      .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_cause(trap_cause),
      .trap_pc(trap_pc), .fault_vaddr(fault_vaddr), .part_vaddr(part_vaddr),
      .part_valid(part_valid), .insn_bits(insn_bits), .sw_we(sw_we),
      .sw_wdata(sw_wdata), .tval_o(tval_o), .epc_o(epc_o)
   );

   tval_unit #(.INFO_MASK(16'h0000)) uut_zero (
      .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_cause(trap_cause),
      .trap_pc(trap_pc), .fault_vaddr(fault_vaddr), .part_vaddr(part_vaddr),
      .part_valid(part_valid), .insn_bits(insn_bits), .sw_we(sw_we),
      .sw_wdata(sw_wdata), .tval_o(tval_z), .epc_o(epc_z)
   );

   function automatic logic [31:0] legal_f(input logic [31:0] v);
      logic [12:0] up;
      up = v[31:VA-1];
      return ((&up) || !(|up)) ? v : FOLD;
   endfunction

   function automatic logic [31:0] exp_trap(input logic [3:0] c,
      input logic [31:0] fa, input logic [31:0] pa, input logic pv,
      input logic [31:0] ins);
      if (!MASK[c]) return '0;
      case (c)
         4'd0, 4'd3, 4'd4, 4'd6:                  return legal_f(fa);
         4'd1, 4'd5, 4'd7, 4'd12, 4'd13, 4'd15:   return legal_f(pv ? pa : fa);
         4'd2:                                    return ins;
         default:                                 return '0;
      endcase
   endfunction

   function automatic logic [31:0] rand_addr();
      logic [31:0] r;
      r = $urandom;
      if (r[0]) return {{12{r[19]}}, r[19:0]};
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input logic tt, input logic [3:0] c,
      input logic [31:0] pc, input logic [31:0] fa, input logic [31:0] pa,
      input logic pv, input logic [31:0] ins, input logic we,
      input logic [31:0] wd);
      @(negedge clk);
      trap_take = tt; trap_cause = c; trap_pc = pc; fault_vaddr = fa;
      part_vaddr = pa; part_valid = pv; insn_bits = ins;
      sw_we = we; sw_wdata = wd;
      if (tt) begin
         m_tval = exp_trap(c, fa, pa, pv, ins);
         m_epc  = pc;
      end else if (we) begin
         m_tval = legal_f(wd);
      end
      @(posedge clk);
      @(negedge clk);
      trap_take = 1'b0; sw_we = 1'b0;
      check(req, tval_o, m_tval);
      check("R6", epc_o, m_epc);
      check("R10", tval_z, 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1", tval_o, 32'h0);
      check("R1", epc_o, 32'h0);

      step("R2", 1, 4'd0, 32'h100, 32'h00012345, 32'h0, 0, 0, 0, 0);
      step("R2", 1, 4'd3, 32'h104, 32'hFFFABCDE, 32'h0, 0, 0, 0, 0);
      step("R3", 1, 4'd5, 32'h108, 32'h00012346, 32'h00012348, 1, 0, 0, 0);
      step("R3", 1, 4'd13, 32'h10C, 32'h00022220, 32'h00022224, 0, 0, 0, 0);
      step("R3", 1, 4'd1, 32'h110, 32'h0000FFFE, 32'h00010000, 1, 0, 0, 0);
      step("R4", 1, 4'd2, 32'h114, 32'h0, 32'h0, 0, 32'hFFFFFFFF, 0, 0);
      step("R5", 1, 4'd11, 32'h118, 32'h00001234, 32'h0, 0, 0, 0, 0);
      step("R5", 1, 4'd6, 32'h11C, 32'h00001235, 32'h0, 0, 0, 0, 0);
      step("R7", 0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 1, 32'h0007FFFF);
      step("R7", 0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, 32'h0);
      step("R8", 1, 4'd3, 32'h120, 32'h00000100, 32'h0, 0, 0, 1, 32'h55);
      step("R9", 0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 1, 32'h12345678);
      step("R9", 1, 4'd4, 32'h124, 32'h80000000, 32'h0, 0, 0, 0, 0);
      step("R9", 0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 1, 32'h00080000);
      step("R10", 0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 1, 32'h00000abc);

      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         step("R2/R3/R4/R5/R7", r[0], r[4:1], $urandom, rand_addr(),
              rand_addr(), r[5], $urandom, r[6], rand_addr());
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule